// File: doc/BRIEF.md
# Alarm Envelope Tone Generator

This block produces the drive for a small piezo buzzer from a clock at 32.768 kHz. A square-wave carrier at 4 kHz, or 2 kHz when a configuration input asks for it, is switched on and off by an envelope. The envelope is the logical AND of any chosen subset of four slow square waves at 8, 4, 2 and 1 Hz. With no envelope wave chosen, the tone is continuous. The tone leaves on a complementary pair of pins while the alarm enable is high. When the enable is low, the same pins carry ordinary port data.

Software programs the envelope through a 4-bit control register. Each write restarts the slow divider chain, so every chosen envelope wave begins its high half in the cycle after the write. The register read path does not return the stored selection. It returns the present level of the four envelope waves, which lets software follow the pattern without disturbing the output.

Top module: `buzzer_envelope_gen`

## Requirements
- R1: With `cfg_2k`=0, the carrier is a square wave with a period of 2^(CAR_LSB+1) clocks. It is low for the first 2^CAR_LSB clocks after reset is released and then alternates. It is derived from a counter that is cleared only by reset.
- R2: With `cfg_2k`=1, the carrier comes from the next slower divider stage. It has a period of 2^(CAR_LSB+2) clocks and is low for the first 2^(CAR_LSB+1) clocks after reset.
- R3: With an envelope selection of 4'b0000, the carrier is never gated. While `alarm_en`=1, exactly one of the two pins is high in every cycle.
- R4: `env_rd` returns the live envelope waves, with bit 0 = 1 Hz, bit 1 = 2 Hz, bit 2 = 4 Hz and bit 3 = 8 Hz. Bit k is high for the first half of each period and low for the second half. Its half period is 2^(ENV_LSB+3-k) clocks, counted from the last write or reset.
- R5: When one or more selection bits are set, the tone passes only in cycles where every selected wave is high. Unselected waves have no influence on the output.
- R6: A write (`wr_en`=1) stores `wr_data` as the selection and clears the envelope chain in that cycle. In the following cycle `env_rd` is 4'b1111. The carrier phase is not changed by a write.
- R7: While `alarm_en`=1 and the gate is open, `pin_p` equals the carrier and `pin_n` its inverse. While the gate is closed, both pins are low.
- R8: While `alarm_en`=0, `pin_p` and `pin_n` follow `gpio_p` and `gpio_n` in the same cycle, whatever the tone state.
- R9: A synchronous active-low reset clears the selection to 4'b0000 and both divider chains to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz-derived clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_2k | input | 1 | 1 selects the 2 kHz carrier, 0 selects 4 kHz |
| alarm_en | input | 1 | 1 routes the tone to the pins |
| wr_en | input | 1 | Write strobe for the envelope selection |
| wr_data | input | 4 | Envelope selection to store |
| env_rd | output | 4 | Live envelope wave levels (read path) |
| gpio_p | input | 1 | Port data for the first pin when the alarm is off |
| gpio_n | input | 1 | Port data for the second pin when the alarm is off |
| pin_p | output | 1 | First buzzer pin |
| pin_n | output | 1 | Second buzzer pin |

## Verification
The bench builds the block with CAR_LSB=1 and ENV_LSB=4 instead of the 32.768 kHz values of 2 and 11. The ratio between the stages is kept, while a full 1 Hz envelope period shrinks from 32768 to 256 clocks. This brings every single-wave and multi-wave burst pattern, several full envelope periods and resyncs taken in mid-period within a few thousand cycles. Each cycle is then compared against the pattern computed from the stated half periods.

// File: rtl/tone_pkg.sv
// Shared definitions for the alarm envelope tone generator.
// Assumes a fixed set of four envelope waves, slowest in bit 0.
package tone_pkg;
    localparam int ENV_N = 4;
    typedef logic [ENV_N-1:0] env_vec_t;
endpackage

// File: rtl/tone_carrier_div.sv
// Free-running carrier divider. The carrier is bit CAR_LSB of the count
// (fast rate) or bit CAR_LSB+1 (half rate). Only reset clears the count.
module tone_carrier_div #(
    parameter int CAR_LSB = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    output logic carrier
);
    localparam int CW = CAR_LSB + 2;

    logic [CW-1:0] cnt;

    // Advance the carrier count every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Pick the stage that matches the requested carrier rate.
    always_comb begin
        carrier = half_rate ? cnt[CAR_LSB+1] : cnt[CAR_LSB];
    end
endmodule

// File: rtl/tone_env_div.sv
// Envelope divider chain. A restart clears the chain, so every wave starts
// high. Wave k has a half period of 2^(ENV_LSB+3-k) clocks (k=0 slowest).
module tone_env_div
    import tone_pkg::*;
#(
    parameter int ENV_LSB = 11
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    output env_vec_t waves
);
    localparam int EW = ENV_LSB + ENV_N;

    logic [EW-1:0] cnt;

    // Count up, clearing on reset or on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Each wave is the inverted stage bit, so it is high right after clearing.
    for (genvar k = 0; k < ENV_N; k++) begin : g_wave
        assign waves[k] = ~cnt[ENV_LSB + ENV_N - 1 - k];
    end
endmodule

// File: rtl/tone_env_gate.sv
// Envelope gate: open only while every selected wave is high.
// An empty selection leaves the gate permanently open.
module tone_env_gate
    import tone_pkg::*;
(
    input  env_vec_t waves,
    input  env_vec_t sel,
    output logic     open
);
    env_vec_t pass;

    // Unselected waves are forced to pass.
    for (genvar k = 0; k < ENV_N; k++) begin : g_pass
        assign pass[k] = waves[k] | ~sel[k];
    end

    // AND of all contributions.
    always_comb begin
        open = &pass;
    end
endmodule

// File: rtl/buzzer_envelope_gen.sv
// Alarm tone generator top: carrier divider, restartable envelope chain,
// selection register, gate and complementary pin mux.
// Assumes clk is the 32.768 kHz base; a write and a read need no handshake.
module buzzer_envelope_gen
    import tone_pkg::*;
#(
    parameter int CAR_LSB = 2,
    parameter int ENV_LSB = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_2k,
    input  logic       alarm_en,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    output logic [3:0] env_rd,
    input  logic       gpio_p,
    input  logic       gpio_n,
    output logic       pin_p,
    output logic       pin_n
);
    env_vec_t env_sel;
    env_vec_t waves;
    logic     carrier;
    logic     gate_open;

    // Hold the envelope selection written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     env_sel <= '0;
        else if (wr_en) env_sel <= wr_data;
    end

    tone_carrier_div #(.CAR_LSB(CAR_LSB)) u_car (
        .clk(clk), .rst_n(rst_n), .half_rate(cfg_2k), .carrier(carrier)
    );

    tone_env_div #(.ENV_LSB(ENV_LSB)) u_env (
        .clk(clk), .rst_n(rst_n), .restart(wr_en), .waves(waves)
    );

    tone_env_gate u_gate (
        .waves(waves), .sel(env_sel), .open(gate_open)
    );

    // Read path returns live wave levels, not the stored selection.
    always_comb begin
        env_rd = waves;
    end

    // Route the gated complementary tone or the port data to the pins.
    always_comb begin
        if (alarm_en) begin
            pin_p = gate_open & carrier;
            pin_n = gate_open & ~carrier;
        end else begin
            pin_p = gpio_p;
            pin_n = gpio_n;
        end
    end
endmodule

// File: rtl/buzzer_envelope_gen_chk.sv
// Property checker for the alarm tone generator, bound to the top.
module buzzer_envelope_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alarm_en,
    input logic       wr_en,
    input logic [3:0] env_rd,
    input logic [3:0] env_sel,
    input logic       gate_open,
    input logic       pin_p,
    input logic       pin_n
);
    // R6: the envelope chain restarts, so every wave reads high after a write.
    a_r6_resync_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (env_rd == 4'hF));

    // R3: an empty selection gives an ungated, complementary tone.
    a_r3_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && env_sel == 4'h0) |-> (pin_p ^ pin_n));

    // R7: both pins are low while the gate is closed.
    a_r7_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && !gate_open) |-> (!pin_p && !pin_n));

    // R7: the pins never drive high together in alarm mode.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en |-> !(pin_p && pin_n));

    // R5: an open gate means every selected wave is high.
    a_r5_gate_and: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> ((env_rd & env_sel) == env_sel));
endmodule

bind buzzer_envelope_gen buzzer_envelope_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .wr_en(wr_en),
    .env_rd(env_rd), .env_sel(env_sel), .gate_open(gate_open),
    .pin_p(pin_p), .pin_n(pin_n)
);

// File: tb/buzzer_envelope_gen_test.sv
module buzzer_envelope_gen_test;
    localparam int CAR_LSB = 1;
    localparam int ENV_LSB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_2k = 1'b0;
    logic       alarm_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] env_rd;
    logic       gpio_p = 1'b0;
    logic       gpio_n = 1'b0;
    logic       pin_p;
    logic       pin_n;

    int total = 0;
    int bad = 0;
    int wd = 0;

    // Bench timeline: clocks since reset release and since the last write.
    int   car_k = 0;
    int   env_m = 0;
    logic [3:0] m_sel = 4'h0;

    always #2.5 clk = ~clk;

    buzzer_envelope_gen #(.CAR_LSB(CAR_LSB), .ENV_LSB(ENV_LSB)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_2k(cfg_2k), .alarm_en(alarm_en),
        .wr_en(wr_en), .wr_data(wr_data), .env_rd(env_rd),
        .gpio_p(gpio_p), .gpio_n(gpio_n), .pin_p(pin_p), .pin_n(pin_n)
    );

    always @(posedge clk) begin
        if (!rst_n) car_k <= 0; else car_k <= car_k + 1;
        if (!rst_n || wr_en) env_m <= 0; else env_m <= env_m + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // R4 wave levels from the stated half periods.
    function automatic logic [3:0] exp_waves();
        logic [3:0] w;
        for (int k = 0; k < 4; k++)
            w[k] = !((env_m >> (ENV_LSB + 3 - k)) & 1);
        return w;
    endfunction

    // R1/R2 carrier level from the stated periods.
    function automatic logic exp_car();
        return ((car_k >> (CAR_LSB + (cfg_2k ? 1 : 0))) & 1) != 0;
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare pins and read path every cycle; one check per window.
    task automatic scan(input string req, input int n);
        logic [5:0] act, exp;
        logic gate, c;
        logic [3:0] w;
        logic miss = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            w = exp_waves();
            c = exp_car();
            gate = ((w | ~m_sel) == 4'hF);
            exp[5:2] = w;
            exp[1] = alarm_en ? (gate & c) : gpio_p;
            exp[0] = alarm_en ? (gate & ~c) : gpio_n;
            act = {env_rd, pin_p, pin_n};
            if (act !== exp && !miss) begin
                miss = 1'b1;
                act = {env_rd, pin_p, pin_n};
                check(req, act, exp);
            end
        end
        if (!miss) check(req, 6'h0, 6'h0);
    endtask

    task automatic write_sel(input logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_sel = v;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        alarm_en = 1'b1;
        m_sel = 4'h0;
        repeat (3) @(negedge clk);
        // R9: cleared chains: waves high, carrier low, empty selection
        check("R9 reset", {env_rd, pin_p, pin_n}, {4'hF, 1'b0, 1'b1});
        rst_n = 1'b1;
        scan("R1 R9 first cycles after reset", 8);
    endtask

    task automatic t_continuous();
        cfg_2k = 1'b0;
        scan("R1 R3 continuous 4k", 64);
        cfg_2k = 1'b1;
        scan("R2 R3 continuous 2k", 64);
        cfg_2k = 1'b0;
    endtask

    task automatic t_single();
        write_sel(4'h8); scan("R4 R5 8Hz envelope", 300);
        write_sel(4'h4); scan("R4 R5 4Hz envelope", 300);
        write_sel(4'h2); scan("R4 R5 2Hz envelope", 300);
        write_sel(4'h1); scan("R4 R5 1Hz envelope", 300);
    endtask

    task automatic t_combo();
        write_sel(4'hC); scan("R5 AND of 8Hz and 4Hz", 300);
        cfg_2k = 1'b1;
        write_sel(4'hF); scan("R2 R5 all four waves", 300);
        cfg_2k = 1'b0;
        write_sel(4'hA); scan("R5 AND of 8Hz and 2Hz", 300);
    endtask

    task automatic t_resync();
        write_sel(4'h8);
        repeat (23) @(negedge clk);
        write_sel(4'h8);
        // R6: one cycle after the write every wave reads high
        check("R6 readback after resync", {2'b00, env_rd}, {2'b00, 4'hF});
        scan("R6 pattern after mid-period resync", 100);
        repeat (37) @(negedge clk);
        write_sel(4'h0);
        scan("R6 R3 selection cleared by write", 40);
    endtask

    task automatic t_passthrough();
        write_sel(4'h3);
        alarm_en = 1'b0;
        gpio_p = 1'b1; gpio_n = 1'b0;
        scan("R8 port data 1/0 with alarm off", 50);
        gpio_p = 1'b0; gpio_n = 1'b1;
        scan("R8 port data 0/1 with alarm off", 50);
        alarm_en = 1'b1;
        scan("R7 alarm back on", 200);
    endtask

    initial begin
        t_reset();
        t_continuous();
        t_single();
        t_combo();
        t_resync();
        t_passthrough();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule